// File: doc/BRIEF.md
# Paged Boot-Overlay Address Decoder

This block decodes every access on a CPU expansion card sitting on a 24-bit, 68000-style bus. It steers each access to one of five targets: on-card RAM, the host's original OS ROM, the card's boot EPROM, the ROM slot on the host bus, or the host's I/O area. It also flags writes that must be dropped and addresses that nothing answers. The routing of the low 64 KiB depends on a one-bit page state. While the overlay is paged in, the CPU executes from the EPROM and can copy the OS ROM into card RAM. Once it is paged out, card RAM stands in for the ROM and is protected from writes.

The page state changes only when the CPU writes to one of two dedicated control addresses. The change takes effect on the access after the write. Decode is combinational, so the select lines are valid in the same cycle as the access strobe. The translated EPROM offset is given alongside the EPROM select.

Top module: `bootmap_decoder`

## Requirements
- R1: After synchronous reset the page state is paged-in (`paged_in` = 1), and it stays so until a page-out write arrives.
- R2: A write to 0x1C060 clears the page state, and a write to 0x1C064 sets it. The new state applies from the next clock cycle. Reads of these two addresses leave the state unchanged. Any access to them asserts no select and no `unmapped`.
- R3: While paged in, reads of 0x00000-0x0BFFF assert `sel_osrom`, and writes to that range assert `sel_ram`.
- R4: While paged in, reads of 0x0C000-0x0FFFF assert `sel_eprom` with `eprom_addr` = address bits 15:0. Writes there assert only `wr_block`. `eprom_addr` is zero whenever `sel_eprom` is low.
- R5: While paged in, reads of 0x40000-0x4FFFF assert `sel_eprom` with `eprom_addr` = address bits 15:0, and writes assert only `wr_block`. While paged out, this range is unmapped.
- R6: While paged out, reads of 0x00000-0x0BFFF assert `sel_ram`, and writes there assert only `wr_block`.
- R7: While paged out, reads of 0x0C000-0x0FFFF assert `sel_slot`, and writes there assert only `wr_block`.
- R8: Accesses to 0x10000-0x17FFF and to 0x1C200-0x1FFFF assert `sel_ram` for reads and writes in both page states.
- R9: Accesses to 0x18000-0x1BFFF assert `sel_extio` for reads and writes in both page states.
- R10: A valid access to any other address asserts no select and raises `unmapped`. With `acc_valid` low, every select, `wr_block` and `unmapped` are low.
- R11: At most one select line is high in any cycle. `wr_block` and `unmapped` are never high together with a select, or with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Byte address of the access |
| sel_ram | output | 1 | Card RAM select |
| sel_osrom | output | 1 | Original OS ROM select |
| sel_eprom | output | 1 | Boot EPROM select |
| sel_slot | output | 1 | Host ROM slot select |
| sel_extio | output | 1 | Host I/O area select |
| wr_block | output | 1 | Write is dropped |
| unmapped | output | 1 | No target answers this address |
| eprom_addr | output | 16 | Offset into the EPROM, valid with sel_eprom |
| paged_in | output | 1 | Current page state |

## Verification
Two functions can land in consecutive clock edges. One is the page-state update caused by a control write. The other is the decode of the following access, which must already see the new state. The write that causes the update must still be decoded under the old state. The bench provokes this by issuing control writes directly before and after reads and writes of the overlaid ranges, with no idle cycle between them, in directed sequences and in a long random stream. Each cycle is judged against a behavioural model whose page bit changes only after the compare for the control write has been made.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    typedef enum logic [3:0] {
        RG_LOWROM,
        RG_HIROM,
        RG_RAMLO,
        RG_HOSTIO,
        RG_CTL_OUT,
        RG_CTL_IN,
        RG_CARDIO,
        RG_RAMHI,
        RG_EPWIN,
        RG_NONE
    } region_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_OSROM,
        TGT_EPROM,
        TGT_SLOT,
        TGT_EXTIO
    } target_e;

    localparam int NUM_TGT = 6;

    typedef struct packed {
        target_e tgt;
        logic    wr_block;
        logic    unmapped;
    } route_t;

    localparam logic [31:0] LOWROM_LO = 32'h0000_0000;
    localparam logic [31:0] LOWROM_HI = 32'h0000_BFFF;
    localparam logic [31:0] HIROM_LO  = 32'h0000_C000;
    localparam logic [31:0] HIROM_HI  = 32'h0000_FFFF;
    localparam logic [31:0] RAMLO_LO  = 32'h0001_0000;
    localparam logic [31:0] RAMLO_HI  = 32'h0001_7FFF;
    localparam logic [31:0] HOSTIO_LO = 32'h0001_8000;
    localparam logic [31:0] HOSTIO_HI = 32'h0001_BFFF;
    localparam logic [31:0] CARDIO_LO = 32'h0001_C000;
    localparam logic [31:0] CARDIO_HI = 32'h0001_C1FF;
    localparam logic [31:0] RAMHI_LO  = 32'h0001_C200;
    localparam logic [31:0] RAMHI_HI  = 32'h0001_FFFF;
    localparam logic [31:0] EPWIN_LO  = 32'h0004_0000;
    localparam logic [31:0] EPWIN_HI  = 32'h0004_FFFF;
    localparam logic [31:0] CTL_OUT_A = 32'h0001_C060;
    localparam logic [31:0] CTL_IN_A  = 32'h0001_C064;

    function automatic logic in_span(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/bootmap_region.sv
module bootmap_region
    import bootmap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    logic [31:0] a;
    assign a = 32'(addr);

    always_comb begin
        region = RG_NONE;
        if (in_span(a, LOWROM_LO, LOWROM_HI))      region = RG_LOWROM;
        else if (in_span(a, HIROM_LO, HIROM_HI))   region = RG_HIROM;
        else if (in_span(a, RAMLO_LO, RAMLO_HI))   region = RG_RAMLO;
        else if (in_span(a, HOSTIO_LO, HOSTIO_HI)) region = RG_HOSTIO;
        else if (a == CTL_OUT_A)                   region = RG_CTL_OUT;
        else if (a == CTL_IN_A)                    region = RG_CTL_IN;
        else if (in_span(a, CARDIO_LO, CARDIO_HI)) region = RG_CARDIO;
        else if (in_span(a, RAMHI_LO, RAMHI_HI))   region = RG_RAMHI;
        else if (in_span(a, EPWIN_LO, EPWIN_HI))   region = RG_EPWIN;
    end
endmodule

// File: rtl/bootmap_page.sv
module bootmap_page (
    input  logic clk,
    input  logic rst,
    input  logic go_in,
    input  logic go_out,
    output logic paged_in
);
    always_ff @(posedge clk) begin
        if (rst)         paged_in <= 1'b1;
        else if (go_out) paged_in <= 1'b0;
        else if (go_in)  paged_in <= 1'b1;
    end
endmodule

// File: rtl/bootmap_route.sv
module bootmap_route
    import bootmap_pkg::*;
(
    input  logic    valid,
    input  logic    write,
    input  region_e region,
    input  logic    paged_in,
    output route_t  route
);
    always_comb begin
        route = '{tgt: TGT_NONE, wr_block: 1'b0, unmapped: 1'b0};
        if (valid) begin
            unique case (region)
                RG_LOWROM: begin
                    if (paged_in)   route.tgt = write ? TGT_RAM : TGT_OSROM;
                    else if (write) route.wr_block = 1'b1;
                    else            route.tgt = TGT_RAM;
                end
                RG_HIROM: begin
                    if (write)         route.wr_block = 1'b1;
                    else if (paged_in) route.tgt = TGT_EPROM;
                    else               route.tgt = TGT_SLOT;
                end
                RG_RAMLO, RG_RAMHI: route.tgt = TGT_RAM;
                RG_HOSTIO:          route.tgt = TGT_EXTIO;
                RG_CTL_OUT, RG_CTL_IN: ;
                RG_EPWIN: begin
                    if (!paged_in)  route.unmapped = 1'b1;
                    else if (write) route.wr_block = 1'b1;
                    else            route.tgt = TGT_EPROM;
                end
                default: route.unmapped = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int EPROM_AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                sel_ram,
    output logic                sel_osrom,
    output logic                sel_eprom,
    output logic                sel_slot,
    output logic                sel_extio,
    output logic                wr_block,
    output logic                unmapped,
    output logic [EPROM_AW-1:0] eprom_addr,
    output logic                paged_in
);
    localparam int NSEL = NUM_TGT - 1;

    region_e           region;
    route_t            route;
    logic              strobe_wr;
    logic [NSEL-1:0]   sel_vec;

    bootmap_region #(.ADDR_W(ADDR_W)) u_region (
        .addr   (acc_addr),
        .region (region)
    );

    assign strobe_wr = acc_valid && acc_write;

    bootmap_page u_page (
        .clk      (clk),
        .rst      (rst),
        .go_in    (strobe_wr && (region == RG_CTL_IN)),
        .go_out   (strobe_wr && (region == RG_CTL_OUT)),
        .paged_in (paged_in)
    );

    bootmap_route u_route (
        .valid    (acc_valid),
        .write    (acc_write),
        .region   (region),
        .paged_in (paged_in),
        .route    (route)
    );

    for (genvar i = 1; i < NUM_TGT; i++) begin : g_sel
        assign sel_vec[i-1] = (route.tgt == target_e'(i));
    end

    assign sel_ram    = sel_vec[int'(TGT_RAM)   - 1];
    assign sel_osrom  = sel_vec[int'(TGT_OSROM) - 1];
    assign sel_eprom  = sel_vec[int'(TGT_EPROM) - 1];
    assign sel_slot   = sel_vec[int'(TGT_SLOT)  - 1];
    assign sel_extio  = sel_vec[int'(TGT_EXTIO) - 1];
    assign wr_block   = route.wr_block;
    assign unmapped   = route.unmapped;
    assign eprom_addr = sel_eprom ? acc_addr[EPROM_AW-1:0] : '0;
endmodule

// File: rtl/bootmap_decoder_chk.sv
module bootmap_decoder_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              sel_ram,
    input logic              sel_osrom,
    input logic              sel_eprom,
    input logic              sel_slot,
    input logic              sel_extio,
    input logic              wr_block,
    input logic              unmapped,
    input logic              paged_in
);
    logic any_sel, ctl_out_wr, ctl_in_wr, ctl_any_wr;
    assign any_sel    = sel_ram | sel_osrom | sel_eprom | sel_slot | sel_extio;
    assign ctl_out_wr = acc_valid && acc_write && (32'(acc_addr) == 32'h1C060);
    assign ctl_in_wr  = acc_valid && acc_write && (32'(acc_addr) == 32'h1C064);
    assign ctl_any_wr = ctl_out_wr || ctl_in_wr;

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ram, sel_osrom, sel_eprom, sel_slot, sel_extio}));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({any_sel, wr_block, unmapped}) <= 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !any_sel && !wr_block && !unmapped);

    // R2
    page_out_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_out_wr |=> !paged_in);

    // R2
    page_in_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_in_wr |=> paged_in);

    // R1
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_any_wr |=> $stable(paged_in));

    // R6
    ram_guard_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write && !paged_in && (32'(acc_addr) < 32'hC000)
        |-> wr_block && !sel_ram);

    // R3
    shadow_rd_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && paged_in && (32'(acc_addr) < 32'hC000)
        |-> sel_osrom);

    // R9
    hostio_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (32'(acc_addr) >= 32'h18000) && (32'(acc_addr) <= 32'h1BFFF)
        |-> sel_extio);
endmodule

bind bootmap_decoder bootmap_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .sel_ram   (sel_ram),
    .sel_osrom (sel_osrom),
    .sel_eprom (sel_eprom),
    .sel_slot  (sel_slot),
    .sel_extio (sel_extio),
    .wr_block  (wr_block),
    .unmapped  (unmapped),
    .paged_in  (paged_in)
);

// File: tb/bootmap_decoder_test.sv
`timescale 1ns/1ps
module bootmap_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        sel_ram, sel_osrom, sel_eprom, sel_slot, sel_extio;
    logic        wr_block, unmapped, paged_in;
    logic [15:0] eprom_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_in = 1;

    always #5 clk = ~clk;

    bootmap_decoder uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .sel_ram(sel_ram), .sel_osrom(sel_osrom),
        .sel_eprom(sel_eprom), .sel_slot(sel_slot), .sel_extio(sel_extio),
        .wr_block(wr_block), .unmapped(unmapped), .eprom_addr(eprom_addr),
        .paged_in(paged_in)
    );

    // expected layout: {ram, osrom, eprom, slot, extio, wr_block, unmapped}
    function automatic bit [6:0] expect_of(bit v, bit w, int a, bit pin);
        if (!v) return 7'b0;
        if (a == 'h1C060 || a == 'h1C064) return 7'b0;
        if (a >= 'h10000 && a < 'h18000) return 7'b1000000;
        if (a >= 'h1C200 && a < 'h20000) return 7'b1000000;
        if (a >= 'h18000 && a < 'h1C000) return 7'b0000100;
        if (a < 'hC000) begin
            if (pin) return w ? 7'b1000000 : 7'b0100000;
            return w ? 7'b0000010 : 7'b1000000;
        end
        if (a < 'h10000) begin
            if (w) return 7'b0000010;
            return pin ? 7'b0010000 : 7'b0001000;
        end
        if (a >= 'h40000 && a < 'h50000 && pin)
            return w ? 7'b0000010 : 7'b0010000;
        return 7'b0000001;
    endfunction

    function automatic string tag_of(bit v, int a, bit pin);
        if (!v) return "R10";
        if (a == 'h1C060 || a == 'h1C064) return "R2";
        if ((a >= 'h10000 && a < 'h18000) || (a >= 'h1C200 && a < 'h20000)) return "R8";
        if (a >= 'h18000 && a < 'h1C000) return "R9";
        if (a < 'hC000) return pin ? "R3" : "R6";
        if (a < 'h10000) return pin ? "R4" : "R7";
        if (a >= 'h40000 && a < 'h50000) return pin ? "R5" : "R10";
        return "R10";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic access(bit v, bit w, int a);
        bit [6:0] e;
        string t;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a[23:0];
        #1;
        e = expect_of(v, w, a, model_in);
        t = tag_of(v, a, model_in);
        check(t, "outputs", {sel_ram, sel_osrom, sel_eprom, sel_slot, sel_extio,
                             wr_block, unmapped}, e);
        check("R4", "eprom_addr", eprom_addr, e[4] ? (a & 'hFFFF) : 0);
        check("R11", "onehot", $countones({sel_ram, sel_osrom, sel_eprom, sel_slot,
                                           sel_extio, wr_block, unmapped}) <= 1, 1);
        check("R2", "page", paged_in, model_in);
        if (v && w && a == 'h1C060) model_in = 0;
        if (v && w && a == 'h1C064) model_in = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "reset page", paged_in, 1);
        check("R10", "reset idle", {sel_ram, sel_osrom, sel_eprom, sel_slot, sel_extio,
                                    wr_block, unmapped}, 0);
        @(negedge clk); rst = 0;
        access(0, 0, 'h0100);                 // R10 idle
        access(1, 0, 'h0100);                 // R3 read OS ROM
        access(1, 1, 'h0100);                 // R3 shadow write
        access(1, 0, 'hC123);                 // R4 EPROM high
        access(1, 1, 'hFFFE);                 // R4 blocked
        access(1, 0, 'h4ABCD);                // R5 window
        access(1, 1, 'h40000);                // R5 blocked write
        access(1, 0, 'h1C060);                // R2 read does not page
        access(1, 0, 'h0100);                 // R2 still in
        access(1, 1, 'h1C060);                // R2 page out
        access(1, 0, 'h0100);                 // R6 RAM read right after
        access(1, 1, 'hBFFF);                 // R6 blocked
        access(1, 0, 'hC000);                 // R7 slot
        access(1, 1, 'hC000);                 // R7 blocked
        access(1, 0, 'h4ABCD);                // R5 unmapped when out
        access(1, 1, 'h17FFF);                // R8
        access(1, 0, 'h1C200);                // R8
        access(1, 1, 'h1BFFF);                // R9
        access(1, 0, 'h1C000);                // R10
        access(1, 0, 'h20000);                // R10
        access(1, 1, 'h1C064);                // R2 page in
        access(1, 0, 'hBFFF);                 // R3 right after
        access(1, 1, 'h1C064);                // R2 repeat in
        access(1, 1, 'h1C060);                // R2 back to back
        access(1, 1, 'h1C064);
        access(1, 0, 'hFFFF);                 // R4
        for (int i = 0; i < 4000; i++) begin
            int base, a;
            int pick = $urandom_range(0, 11);
            case (pick)
                0: base = 'h0;  1: base = 'h8000; 2: base = 'hC000;
                3: base = 'h10000; 4: base = 'h18000; 5: base = 'h1C000;
                6: base = 'h1C200; 7: base = 'h40000; 8: base = 'h50000;
                9: base = 'h1C060; 10: base = 'h1C064; default: base = 'hFF000;
            endcase
            a = (pick == 9 || pick == 10) ? base : base + $urandom_range(0, 'h3FFF);
            access($urandom_range(0, 7) != 0, $urandom_range(0, 1), a);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule